// File: doc/BRIEF.md
# Usage-Bit Random Victim Selector

This block chooses which of 16 cache sectors is given up when a new main-storage region needs a place in the cache. It keeps a single usage flag per sector as a coarse record of recent activity. Every reference to a sector raises that sector's flag. When raising a flag would leave no flag low, the flag being raised stays high and every other flag drops in the same cycle. A low flag therefore marks a sector that has not been touched since the last such wrap.

When a victim is requested, the block draws one sector at random from the sectors whose flag is low. The draw uses a free-running pseudo-random sequence. The chosen sector is returned one cycle after the request. Because the new occupant of that sector is about to be used, the chosen sector is treated as referenced, so its flag is raised as part of the allocation. Tag and data storage sit outside this block: a cache controller sends it reference strobes and victim requests.

Top module: `usage_repl_select`

## Requirements
- R1: After a synchronous active-high reset every usage flag is low, `victim_valid` is low, and the random sequence holds the seed 16'hACE1 on the first clock edge after reset is released.
- R2: A reference (`ref_valid` high with `ref_sector`) raises that sector's flag, so the sector is not chosen by a later request until the flags wrap.
- R3: When a clock edge would leave every flag high, only the flags being raised on that edge stay high and all others drop. At least one flag is therefore always low.
- R4: On a request, the low flags are ranked by ascending sector index starting at rank 0. The victim is the sector at rank (L mod C), where L is the random state at that edge and C is the number of low flags.
- R5: `victim_valid` is high on exactly the cycle after each request edge and low otherwise. `victim_sector` carries the victim on that cycle.
- R6: The chosen victim's flag is raised on the request edge, so the victim counts as referenced.
- R7: The random state advances on every clock edge out of reset, whether or not there is any request. The next state is the old state shifted left by one bit, with bit 0 taking the XOR of old bits 15, 13, 12 and 10.
- R8: When a reference and a request share an edge, the victim is drawn from the flags as they were before that edge. Both the referenced sector and the victim are raised, and R3 applies to the pair.
- R9: A reference to a sector whose flag is already high changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference strobe |
| ref_sector | input | 4 | Sector referenced |
| victim_req | input | 1 | Request for a replacement victim |
| victim_valid | output | 1 | Victim result valid, one cycle after a request |
| victim_sector | output | 4 | Chosen victim sector |

## Verification
A victim is due on the falling edge that follows the rising edge that samples its request. The bench drives every input at a falling edge and reads `victim_valid` and `victim_sector` at the next falling edge, before it drives anything new. A reference or allocation has no output of its own, so its effect on the flags is checked through the next request. The scenarios are built so that only one sector, or a known pair of sectors, is still eligible, which lets the victim or its range be known exactly. A bench model of the flags and the random sequence, computed from the requirements and advanced on the same rising edges, checks every cycle of the swept and random phases.

// File: rtl/usage_repl_pkg.sv
package usage_repl_pkg;

    localparam int SECTORS   = 16;
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // x^16 + x^14 + x^13 + x^11 + 1, shift-left form
    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    typedef enum logic [1:0] {
        UPD_HOLD   = 2'd0,
        UPD_MERGE  = 2'd1,
        UPD_WRAP   = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/usage_lfsr.sv
module usage_lfsr
    import usage_repl_pkg::*;
#(
    parameter int LW = LFSR_W,
    parameter logic [LW-1:0] SEED = LFSR_SEED
) (
    input  logic          clk,
    input  logic          rst,
    output logic [LW-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= lfsr_next(state);
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state != '0); // R7

endmodule

// File: rtl/usage_bit_array.sv
module usage_bit_array
    import usage_repl_pkg::*;
#(
    parameter int N_SECT = SECTORS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SECT-1:0] set_mask,
    output logic [N_SECT-1:0] usage
);

    typedef struct packed {
        upd_kind_e         kind;
        logic [N_SECT-1:0] value;
    } upd_t;

    upd_t upd;

    always_comb begin
        upd.value = usage | set_mask;
        if (set_mask == '0) begin
            upd.kind = UPD_HOLD;
        end else if (&upd.value) begin
            upd.kind  = UPD_WRAP;
            upd.value = set_mask;
        end else begin
            upd.kind = UPD_MERGE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    usage <= '0;
        else if (upd.kind != UPD_HOLD) usage <= upd.value;
    end

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(&usage)); // R3

    AST_MASK_SETS: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((usage & $past(set_mask)) == $past(set_mask))); // R2

    AST_WRAP_KEEPS_ONLY_MASK: assert property (@(posedge clk) disable iff (rst)
        (&(usage | set_mask)) |=> (usage == $past(set_mask))); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0) |=> $stable(usage)); // R9

endmodule

// File: rtl/usage_victim_pick.sv
module usage_victim_pick
    import usage_repl_pkg::*;
#(
    parameter int N_SECT = SECTORS,
    parameter int LW     = LFSR_W,
    localparam int IDX_W = $clog2(N_SECT),
    localparam int CNT_W = $clog2(N_SECT + 1)
) (
    input  logic [N_SECT-1:0] usage,
    input  logic [LW-1:0]     rnd,
    output logic [IDX_W-1:0]  pick
);

    logic [CNT_W-1:0] clear_cnt;
    logic [LW-1:0]    rank;
    logic [CNT_W-1:0] seen;

    always_comb begin
        clear_cnt = '0;
        for (int i = 0; i < N_SECT; i++) begin
            clear_cnt = clear_cnt + CNT_W'(!usage[i]);
        end
    end

    always_comb begin
        if (clear_cnt == '0) rank = '0;
        else                 rank = rnd % LW'(clear_cnt);
    end

    always_comb begin
        pick = '0;
        seen = '0;
        for (int i = 0; i < N_SECT; i++) begin
            if (!usage[i]) begin
                if (LW'(seen) == rank) pick = IDX_W'(i);
                seen = seen + 1'b1;
            end
        end
    end

    always_comb begin
        AST_PICK_IS_CLEAR: assert ((&usage) || !usage[pick]); // R4
    end

endmodule

// File: rtl/usage_repl_select.sv
module usage_repl_select
    import usage_repl_pkg::*;
#(
    parameter int N_SECT = SECTORS,
    parameter int LW     = LFSR_W,
    localparam int IDX_W = $clog2(N_SECT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_sector,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_sector
);

    logic [LW-1:0]     rnd;
    logic [N_SECT-1:0] usage;
    logic [N_SECT-1:0] set_mask;
    logic [IDX_W-1:0]  pick;

    usage_lfsr #(.LW(LW)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (rnd)
    );

    usage_victim_pick #(.N_SECT(N_SECT), .LW(LW)) u_pick (
        .usage (usage),
        .rnd   (rnd),
        .pick  (pick)
    );

    always_comb begin
        for (int i = 0; i < N_SECT; i++) begin
            set_mask[i] = (ref_valid  && (ref_sector == IDX_W'(i))) ||
                          (victim_req && (pick       == IDX_W'(i)));
        end
    end

    usage_bit_array #(.N_SECT(N_SECT)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .usage    (usage)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid  <= 1'b0;
            victim_sector <= '0;
        end else begin
            victim_valid <= victim_req;
            if (victim_req) victim_sector <= pick;
        end
    end

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        victim_req |=> victim_valid); // R5

    AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !victim_req |=> !victim_valid); // R5

    AST_VICTIM_MARKED: assert property (@(posedge clk) disable iff (rst)
        victim_req |=> usage[victim_sector]); // R6

    AST_REF_MARKED: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> usage[$past(ref_sector)]); // R8

endmodule

// File: tb/usage_repl_select_tb.sv
`timescale 1ns/1ps
module usage_repl_select_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_valid = 1'b0;
    logic [3:0] ref_sector = '0;
    logic       victim_req = 1'b0;
    logic       victim_valid;
    logic [3:0] victim_sector;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    usage_repl_select u_dut (
        .clk           (clk),
        .rst           (rst),
        .ref_valid     (ref_valid),
        .ref_sector    (ref_sector),
        .victim_req    (victim_req),
        .victim_valid  (victim_valid),
        .victim_sector (victim_sector)
    );

    // ---------------- bench model, from the requirements ----------------
    logic [15:0] m_use;
    logic [15:0] m_rnd;
    logic        m_vv;
    logic [3:0]  m_vs;

    function automatic logic [3:0] model_pick(input logic [15:0] u, input logic [15:0] r);
        int clear = 0;
        int rank;
        int k = 0;
        for (int i = 0; i < 16; i++) if (!u[i]) clear++;
        rank = (clear == 0) ? 0 : int'(r) % clear;
        for (int i = 0; i < 16; i++) begin
            if (!u[i]) begin
                if (k == rank) return 4'(i);
                k++;
            end
        end
        return 4'd0;
    endfunction

    always @(posedge clk) begin : model
        logic [15:0] mask;
        logic [15:0] merged;
        logic [3:0]  p;
        if (rst) begin
            m_use <= '0;
            m_rnd <= 16'hACE1;
            m_vv  <= 1'b0;
            m_vs  <= '0;
        end else begin
            mask = '0;
            p    = model_pick(m_use, m_rnd);
            if (ref_valid)  mask[ref_sector] = 1'b1;
            if (victim_req) mask[p] = 1'b1;
            merged = m_use | mask;
            if (merged == 16'hFFFF) merged = mask;
            m_use <= merged;
            m_rnd <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
            m_vv  <= victim_req;
            if (victim_req) m_vs <= p;
        end
    end

    // cycle monitor: R5 timing and R4/R7 victim value
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (victim_valid !== m_vv) begin
                n_fails++;
                $display("FAIL R5 victim_valid actual %0b expected %0b at %0t", victim_valid, m_vv, $time);
            end
            if (m_vv) begin
                n_checks++;
                if (victim_sector !== m_vs) begin
                    n_fails++;
                    $display("FAIL R4 R7 victim_sector actual %0d expected %0d at %0t", victim_sector, m_vs, $time);
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ref_valid = 1'b0;
        victim_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at a falling edge, advance one cycle, release
    task automatic cyc(input bit rv, input int rs, input bit rq);
        ref_valid  = rv;
        ref_sector = 4'(rs);
        victim_req = rq;
        @(negedge clk);
        ref_valid  = 1'b0;
        victim_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v1;
        int v2;
        @(negedge clk);

        // R1: reset state, seed 0xACE1 mod 16 = 1 with all flags low
        do_reset();
        check(victim_valid == 1'b0, "R1 valid after reset", victim_valid, 0);
        cyc(0, 0, 1);
        check(victim_valid == 1'b1, "R5 valid after request", victim_valid, 1);
        check(victim_sector == 4'd1, "R1 first victim from seed", victim_sector, 1);
        cyc(0, 0, 0);
        check(victim_valid == 1'b0, "R5 valid drops", victim_valid, 0);

        // R2 / R6 / R3: fill 0..13, two allocations, then wrap
        do_reset();
        for (int s = 0; s < 14; s++) cyc(1, s, 0);
        cyc(0, 0, 1);
        v1 = victim_sector;
        check(v1 == 14 || v1 == 15, "R2 victim among unreferenced", v1, 14);
        cyc(0, 0, 1);
        v2 = victim_sector;
        check(v2 == 29 - v1, "R6 previous victim now referenced", v2, 29 - v1);
        cyc(0, 0, 1);
        check(victim_sector != 4'(v2), "R3 wrap kept only last set flag", victim_sector, 99);

        // R9: repeat reference to a set sector does not wrap or change
        do_reset();
        for (int s = 0; s < 15; s++) cyc(1, s, 0);
        cyc(1, 3, 0);
        cyc(0, 0, 1);
        check(victim_sector == 4'd15, "R9 repeat reference no effect", victim_sector, 15);
        cyc(1, 15, 0);
        cyc(0, 0, 1);
        check(victim_sector != 4'd15, "R3 wrap by allocation of last clear", victim_sector, 99);

        // R8: reference and request on one edge
        do_reset();
        for (int s = 0; s < 14; s++) cyc(1, s, 0);
        cyc(1, 14, 1);
        v1 = victim_sector;
        check(v1 == 14 || v1 == 15, "R8 victim from pre-edge flags", v1, 14);
        cyc(0, 0, 1);
        if (v1 == 15)
            check(victim_sector < 4'd14, "R8 pair wrap keeps both", victim_sector, 13);
        else
            check(victim_sector == 4'd15, "R8 shared sector single set", victim_sector, 15);

        // R7 / R4: idle gaps change the draw; model covers each cycle
        do_reset();
        repeat (7) cyc(0, 0, 0);
        for (int k = 0; k < 40; k++) cyc(0, 0, 1);

        // sweep: every sector referenced in turn, periodic requests
        for (int round = 0; round < 4; round++)
            for (int s = 0; s < 16; s++) cyc(1, s, (s % 5) == 0);

        // random mix
        for (int k = 0; k < 6000; k++)
            cyc(($urandom % 3) != 0, int'($urandom % 16), ($urandom % 4) == 0);

        do_reset();
        for (int k = 0; k < 2000; k++)
            cyc(($urandom % 2) != 0, int'($urandom % 16), ($urandom % 2) == 0);

        finish_run();
    end

endmodule